// File: doc/BRIEF.md
# Dual-Channel Serial DAC Writer

This block turns a pair of 12-bit sample words into serial frames for two identical voltage-output converters that are updated together. Both converters share one active-low frame-sync line and one serial clock. Each converter has its own data line, so the two channels shift in lockstep. The serial clock is made from the system clock by a divide parameter, `HALF_DIV`, which gives the number of system clocks per half-period. An elaboration-time check rejects any `HALF_DIV` below 1, and any setting whose serial clock would exceed `SCLK_MAX_HZ`.

A requester presents both samples and pulses `start_i`. The request is taken only while `ready_o` is high. The block then enforces a minimum update period, so the analog outputs have time to settle. This period is derived from `SYS_CLK_HZ` and `SETTLE_NS`. With the defaults (25 MHz, 8000 ns) it is 200 system clocks, which allows at most 125,000 updates per second. The rate limit is held in hardware, so a requester that retries too fast cannot overrun the converters.

Top module: `dual_dac_writer`

## Requirements
- R1: After reset, `ready_o`=1, `sync_no`=1, `sclk_o`=1, `sdo_a_o`=0 and `sdo_b_o`=0.
- R2: A `start_i` sampled high while `ready_o`=1 is accepted. In the next cycle `sync_no` is 0 and `ready_o` is 0. `sync_no` then stays low for exactly 32*HALF_DIV cycles.
- R3: Each frame is 16 bits, sent MSB first. Bits 15..14 are filler sent as 0. Bits 13..12 are the power mode, sent as 00 (normal operation). Bits 11..0 are the sample, bit 11 first. The converter takes each bit at a falling edge of `sclk_o`.
- R4: The data lines change only in the same cycle as a rising edge of `sclk_o`. They are stable across every falling edge. Frame bit 15 is on the lines from the first cycle of `sync_no` low.
- R5: `sclk_o` is high whenever `sync_no` is high. Every low phase and every high phase of `sclk_o` within a frame lasts HALF_DIV cycles. There are exactly 16 falling edges per frame.
- R6: `sdo_b_o` carries the frame for `sample_b_i` under the same sync and clock, bit for bit in lockstep with `sdo_a_o`.
- R7: Both samples are captured in the accept cycle. Changes on `sample_a_i` or `sample_b_i` during a frame have no effect on that frame.
- R8: After the last bit, `sync_no` and `sclk_o` are both high for at least 2*HALF_DIV cycles before `ready_o` can rise.
- R9: `ready_o` is high only when no frame is in progress and MIN_PERIOD_CYC cycles have passed since the last accept. MIN_PERIOD_CYC is ceil(SYS_CLK_HZ*SETTLE_NS/1e9). When the frame is shorter than this period, `ready_o` rises exactly MIN_PERIOD_CYC cycles after an accept, so a start held high is accepted every MIN_PERIOD_CYC cycles.
- R10: A `start_i` while `ready_o`=0 is ignored. The frame in progress is unchanged, `sync_no` stays high after it, and `ready_o` rises at the same cycle as without the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Update request strobe |
| sample_a_i | input | 12 | Sample for converter A |
| sample_b_i | input | 12 | Sample for converter B |
| ready_o | output | 1 | Block idle and settling interval expired |
| sync_no | output | 1 | Shared frame sync, active low |
| sclk_o | output | 1 | Shared serial clock, idles high |
| sdo_a_o | output | 1 | Serial data to converter A |
| sdo_b_o | output | 1 | Serial data to converter B |

## Verification
The bench watches each port at every cycle and checks the following:
- A wrong bit counter shows within one frame, as a sync-low window that is not 32*HALF_DIV cycles long, or as a falling-edge count other than 16.
- A wrong divide counter shows at the first clock low phase whose length is not HALF_DIV.
- A shifter that loads or shifts in the wrong cycle shows within the same frame, as a data change away from a rising clock edge or as a wrong captured word.
- Rate-gate faults show at the end of the first settling interval, as `ready_o` rising at any cycle other than MIN_PERIOD_CYC after the accept.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;
  localparam int SAMPLE_BITS = 12;
  localparam int HDR_BITS    = 4;
  localparam int FRAME_BITS  = SAMPLE_BITS + HDR_BITS;
  localparam int BIT_CW      = $clog2(FRAME_BITS);

  localparam logic [1:0] FILL_BITS   = 2'b00;
  localparam logic [1:0] MODE_NORMAL = 2'b00;
  localparam logic [HDR_BITS-1:0] FRAME_HDR = {FILL_BITS, MODE_NORMAL};

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dac_sclk_tick.sv
module dac_sclk_tick #(
  parameter int HALF_DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/dac_frame_seq.sv
module dac_frame_seq
  import dac_wr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic tick_i,
  output logic sync_no,
  output logic sclk_o,
  output logic shift_o,
  output logic busy_o
);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(FRAME_BITS - 1);

  seq_state_e        state_q;
  logic [BIT_CW-1:0] bit_q;
  logic              gap_half_q;
  logic              sync_q, sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      gap_half_q <= 1'b0;
      sync_q     <= 1'b1;
      sclk_q     <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          sclk_q <= 1'b1;
          if (go_i) begin
            state_q <= ST_SHIFT;
            sync_q  <= 1'b0;
            bit_q   <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick_i) begin
            if (sclk_q) begin
              sclk_q <= 1'b0;
            end else begin
              sclk_q <= 1'b1;
              if (bit_q == LAST_BIT) begin
                state_q    <= ST_GAP;
                sync_q     <= 1'b1;
                gap_half_q <= 1'b0;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          end
        end
        ST_GAP: begin
          // one full serial clock period with sync released
          if (tick_i) begin
            if (!gap_half_q) gap_half_q <= 1'b1;
            else             state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign shift_o = (state_q == ST_SHIFT) && tick_i && !sclk_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign sync_no = sync_q;
  assign sclk_o  = sclk_q;
endmodule

// File: rtl/dac_rate_gate.sv
module dac_rate_gate #(
  parameter int PERIOD = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic open_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (load_i)     cnt_q <= RELOAD;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign open_o = (cnt_q == '0);
endmodule

// File: rtl/dac_shift_chan.sv
module dac_shift_chan
  import dac_wr_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic                   shift_i,
  input  logic [SAMPLE_BITS-1:0] data_i,
  output logic                   sdo_o
);
  logic [FRAME_BITS-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (load_i)  sreg_q <= {FRAME_HDR, data_i};
    else if (shift_i) sreg_q <= {sreg_q[FRAME_BITS-2:0], 1'b0};
  end

  assign sdo_o = sreg_q[FRAME_BITS-1];
endmodule

// File: rtl/dual_dac_writer.sv
module dual_dac_writer
  import dac_wr_pkg::*;
#(
  parameter int SYS_CLK_HZ  = 25_000_000,
  parameter int SCLK_MAX_HZ = 30_000_000,
  parameter int HALF_DIV    = 1,
  parameter int SETTLE_NS   = 8000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [SAMPLE_BITS-1:0] sample_a_i,
  input  logic [SAMPLE_BITS-1:0] sample_b_i,
  output logic                   ready_o,
  output logic                   sync_no,
  output logic                   sclk_o,
  output logic                   sdo_a_o,
  output logic                   sdo_b_o
);
  localparam longint SETTLE_PROD    = longint'(SYS_CLK_HZ) * longint'(SETTLE_NS);
  localparam int     MIN_PERIOD_CYC = int'((SETTLE_PROD + 64'd999_999_999) / 64'd1_000_000_000);
  localparam int     NUM_CH         = 2;

  if (HALF_DIV < 1 ||
      longint'(SYS_CLK_HZ) > 2 * longint'(HALF_DIV) * longint'(SCLK_MAX_HZ)) begin : g_bad_div
    $error("HALF_DIV gives a serial clock above SCLK_MAX_HZ or is below 1");
  end

  if (MIN_PERIOD_CYC < 1) begin : g_bad_settle
    $error("settling period must be at least one cycle");
  end

  logic tick, shift, busy, gate_open, accept;
  logic [SAMPLE_BITS-1:0] samples [NUM_CH];
  logic [NUM_CH-1:0]      sdo;

  assign ready_o = !busy && gate_open;
  assign accept  = start_i && ready_o;

  dac_sclk_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .tick_o (tick)
  );

  dac_frame_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (accept),
    .tick_i  (tick),
    .sync_no (sync_no),
    .sclk_o  (sclk_o),
    .shift_o (shift),
    .busy_o  (busy)
  );

  dac_rate_gate #(.PERIOD(MIN_PERIOD_CYC)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .open_o (gate_open)
  );

  assign samples[0] = sample_a_i;
  assign samples[1] = sample_b_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dac_shift_chan u_shift (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (accept),
      .shift_i (shift),
      .data_i  (samples[c]),
      .sdo_o   (sdo[c])
    );
  end

  assign sdo_a_o = sdo[0];
  assign sdo_b_o = sdo[1];
endmodule

// File: rtl/dual_dac_writer_chk.sv
module dual_dac_writer_chk #(
  parameter int HALF_DIV       = 1,
  parameter int MIN_PERIOD_CYC = 200
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic ready_o,
  input logic sync_no,
  input logic sclk_o,
  input logic sdo_a_o,
  input logic sdo_b_o
);
  int  lo_len;
  int  since_acc;
  logic seen_acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_len    <= 0;
      since_acc <= 0;
      seen_acc  <= 1'b0;
    end else begin
      lo_len <= sclk_o ? 0 : lo_len + 1;
      if (start_i && ready_o) begin
        since_acc <= 1;
        seen_acc  <= 1'b1;
      end else if (since_acc < MIN_PERIOD_CYC) begin
        since_acc <= since_acc + 1;
      end
    end
  end

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> (!sync_no && !ready_o));

  p_data_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> ($stable(sdo_a_o) && $stable(sdo_b_o)));

  p_sclk_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_no |-> sclk_o);

  p_half_period_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> (lo_len == HALF_DIV));

  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_no) |-> !ready_o);

  p_ready_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> sync_no);

  p_spacing_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o && seen_acc) |-> (since_acc >= MIN_PERIOD_CYC));
endmodule

bind dual_dac_writer dual_dac_writer_chk #(
  .HALF_DIV       (HALF_DIV),
  .MIN_PERIOD_CYC (MIN_PERIOD_CYC)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .ready_o (ready_o),
  .sync_no (sync_no),
  .sclk_o  (sclk_o),
  .sdo_a_o (sdo_a_o),
  .sdo_b_o (sdo_b_o)
);

// File: tb/dual_dac_writer_tb.sv
module dual_dac_writer_tb;
  localparam int SYS_HZ = 25_000_000;
  localparam int H      = 2;
  localparam int SET_NS = 8000;
  localparam int P      = 200;   // ceil(25e6 * 8000e-9)
  localparam int LOW_W  = 32 * H;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [11:0] sample_a_i = '0, sample_b_i = '0;
  logic ready_o, sync_no, sclk_o, sdo_a_o, sdo_b_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_dac_writer #(
    .SYS_CLK_HZ (SYS_HZ),
    .HALF_DIV   (H),
    .SETTLE_NS  (SET_NS)
  ) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .sample_a_i (sample_a_i),
    .sample_b_i (sample_b_i),
    .ready_o    (ready_o),
    .sync_no    (sync_no),
    .sclk_o     (sclk_o),
    .sdo_a_o    (sdo_a_o),
    .sdo_b_o    (sdo_b_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(ready_o == 1'b1, "R1", "ready after reset", ready_o, 1);
    check(sync_no == 1'b1, "R1", "sync after reset", sync_no, 1);
    check(sclk_o == 1'b1, "R1", "sclk after reset", sclk_o, 1);
    check({sdo_a_o, sdo_b_o} == 2'b00, "R1", "data after reset", {sdo_a_o, sdo_b_o}, 0);
  endtask

  task automatic t_frame(input logic [11:0] a, input logic [11:0] b,
                         input bit alter, input int poke_at, input string tag);
    int sync_err = 0, edge_err = 0, lo_err = 0, gap_err = 0;
    int falls = 0, lo = 0, ready_at = -1;
    logic pk = 1'b1, pa = 1'b0, pb = 1'b0;
    logic [15:0] cap_a = '0, cap_b = '0;
    while (!ready_o) @(negedge clk);
    sample_a_i = a;
    sample_b_i = b;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (alter) begin
      sample_a_i = ~a;
      sample_b_i = ~b;
    end
    check(!sync_no && !ready_o, "R2", {tag, " sync low and ready low after accept"},
          {sync_no, ready_o}, 0);
    for (int n = 1; n <= P + 4; n++) begin
      if (n <= LOW_W && sync_no) sync_err++;
      if (n > LOW_W && !sync_no) sync_err++;
      if (n > LOW_W && n <= LOW_W + 2 * H && !(sync_no && sclk_o)) gap_err++;
      if ((sdo_a_o != pa || sdo_b_o != pb) && !(!pk && sclk_o)) edge_err++;
      if (pk && !sclk_o) begin
        falls++;
        cap_a = {cap_a[14:0], sdo_a_o};
        cap_b = {cap_b[14:0], sdo_b_o};
      end
      if (!sclk_o) lo++;
      if (!pk && sclk_o) begin
        if (lo != H) lo_err++;
        lo = 0;
      end
      pk = sclk_o; pa = sdo_a_o; pb = sdo_b_o;
      if (ready_o) begin
        ready_at = n;
        break;
      end
      start_i = (n == poke_at);
      @(negedge clk);
    end
    start_i = 1'b0;
    check(sync_err == 0, "R2", {tag, " sync low window length"}, sync_err, 0);
    check(cap_a == {4'b0000, a}, "R3", {tag, " frame on channel A"}, cap_a, {4'b0000, a});
    check(cap_b == {4'b0000, b}, "R6", {tag, " frame on channel B"}, cap_b, {4'b0000, b});
    check(edge_err == 0, "R4", {tag, " data change away from rising edge"}, edge_err, 0);
    check(falls == 16, "R5", {tag, " falling edges per frame"}, falls, 16);
    check(lo_err == 0, "R5", {tag, " low phase length"}, lo_err, 0);
    check(gap_err == 0, "R8", {tag, " sync and sclk high after frame"}, gap_err, 0);
    check(ready_at == P, "R9", {tag, " ready return cycle"}, ready_at, P);
    if (alter)
      check(cap_a == {4'b0000, a} && cap_b == {4'b0000, b}, "R7",
            {tag, " sample change during frame"}, cap_a, {4'b0000, a});
    if (poke_at > 0)
      check(sync_err == 0 && ready_at == P, "R10", {tag, " start while busy ignored"},
            ready_at, P);
    sample_a_i = '0;
    sample_b_i = '0;
  endtask

  task automatic t_spacing();
    int n = 0;
    bit seen_hi = 1'b0;
    while (!ready_o) @(negedge clk);
    start_i = 1'b1;
    while (sync_no) @(negedge clk);
    for (int k = 0; k < 4 * P; k++) begin
      @(negedge clk);
      n++;
      if (sync_no) seen_hi = 1'b1;
      if (seen_hi && !sync_no) break;
    end
    start_i = 1'b0;
    check(n == P, "R9", "accept spacing with start held high", n, P);
    while (!ready_o) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_frame(12'hA5A, 12'h5A5, 1'b0, 0, "alt");
    t_frame(12'hFFF, 12'h000, 1'b0, 0, "ones");
    t_frame(12'h800, 12'h001, 1'b0, 0, "ends");
    t_frame(12'h3C7, 12'hE18, 1'b1, 0, "alter");
    t_frame(12'h123, 12'hFED, 1'b0, 9, "poke_busy");
    t_frame(12'h456, 12'h789, 1'b0, LOW_W + 20, "poke_settle");
    t_spacing();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50_000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule